// File: doc/BRIEF.md
# Jumper-Selectable Periodic Interrupt Generator

This block produces the recurring interrupt request of a small 8-bit processor board. A free-running divide-by-four stage turns the 4 MHz input clock into a one-cycle enable once every four clocks, which acts as a 1 MHz bus tick. The timing counters advance only on that enable, so the whole block runs on the input clock with no second clock domain. The request alternates between a quiet gap and an active pulse of fixed length. Two board jumpers pick one of four gap lengths.

Besides the request itself, the block drives three side lines. The first is an inverted copy of the request for a peripheral adapter. The second carries a diagnostic push-button through to another adapter while the request is active and is otherwise held high. The third is a status flag. An external clear drops a pulse that is in progress and restarts the full gap, and it also keeps the request quiet for as long as it is held.

Top module: `irq_pacer`

## Requirements
- R1: Every change of the request happens on a bus-tick edge, and bus ticks come once every 4 input clocks. Phase lengths are therefore whole multiples of 4 input clocks.
- R2: The quiet gap lasts G ticks (4·G input clocks), where G depends on the loaded jumper code: 0 → 768 (0x300), 1 → 896 (0x380), 2 → 1792 (0x700), 3 → 1920 (0x780). The code is jmp_sel[1:0], with bit 1 as the high jumper.
- R3: Once it rises, the request stays high for exactly 32 ticks, which is 128 input clocks.
- R4: The jumpers are sampled only when a gap is loaded: on the first clock after reset, at the end of a pulse, and on a clear. A jumper change during a gap or during a pulse has no effect on the gap already loaded.
- R5: mirror_o is low while the request is high and high while it is low.
- R6: While the request is high, diag_o equals advance_i. While the request is low, diag_o is 1.
- R7: A clear sampled on a clock edge drops the request and the status flag at that edge and resets the gap count to zero. While the clear is held, the request stays low. After the clear is released, the next request rises between 4·G−3 and 4·G input clocks later.
- R8: Out of reset, the request is low, mirror_o and diag_o are high, and busy_o is low. The first request arrives after one full gap of the jumper code that was present on the first clock after reset.
- R9: When a clear falls on the same tick that ends a pulse, the clear takes priority. The outcome is the same as a normal pulse end: low, followed by a full gap of exactly 4·G input clocks.
- R10: busy_o is 1 exactly while the request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| jmp_sel | input | 2 | Jumper code that selects the gap length |
| clear_i | input | 1 | Synchronous clear, active high: drops the request and restarts the gap |
| advance_i | input | 1 | Diagnostic "advance" push-button level |
| irq_o | output | 1 | Interrupt request, active high |
| mirror_o | output | 1 | Inverted copy of the request for a peripheral adapter |
| diag_o | output | 1 | Button pass-through while active, otherwise high |
| busy_o | output | 1 | Status flag, high while the request is active |

## Verification
A divider that slips or a tick counter that is off by one shows up at irq_o within a single pulse. The high time then differs from 128 clocks, or a gap differs from 4·G, and the bench measures every phase to the clock. A wrong gap-code latch, or a jumper that leaks through mid-gap, shows up one gap later as a gap length from the wrong table entry. A clear that fails to reset the phase or the count shows at the very next clock edge as a request still high, or one gap later as a restart outside the 4·G−3..4·G window. Side-line faults show up on the same sample as the request level they must track.

// File: rtl/irq_pacer_pkg.sv
package irq_pacer_pkg;

  typedef enum logic {
    PH_QUIET = 1'b0,
    PH_PULSE = 1'b1
  } pacer_phase_e;

  function automatic int unsigned pick_gap(input logic [1:0] code,
                                           input int unsigned g0,
                                           input int unsigned g1,
                                           input int unsigned g2,
                                           input int unsigned g3);
    case (code)
      2'd0:    return g0;
      2'd1:    return g1;
      2'd2:    return g2;
      default: return g3;
    endcase
  endfunction

  function automatic int unsigned max_of(input int unsigned a,
                                         input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v);
  endfunction

endpackage

// File: rtl/irq_pacer_tick.sv
module irq_pacer_tick #(
  parameter int unsigned DIV_RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned DW = irq_pacer_pkg::bits_for(DIV_RATIO);

  generate
    if (DIV_RATIO <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [DW-1:0] phase_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          phase_q <= '0;
        end else if (phase_q == DW'(DIV_RATIO - 1)) begin
          phase_q <= '0;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
      assign tick_o = (phase_q == DW'(DIV_RATIO - 1));
    end
  endgenerate
endmodule

// File: rtl/irq_pacer_seq.sv
module irq_pacer_seq
  import irq_pacer_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 32,
  parameter int unsigned GAP_SEL0    = 768,
  parameter int unsigned GAP_SEL1    = 896,
  parameter int unsigned GAP_SEL2    = 1792,
  parameter int unsigned GAP_SEL3    = 1920,
  parameter int unsigned CNT_W       = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       clear_i,
  input  logic [1:0] gap_sel_i,
  output logic       active_o,
  output logic       gap_done_o,
  output logic       pulse_done_o
);
  pacer_phase_e     phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       code_q;
  logic             load_pend_q;
  logic [CNT_W-1:0] gap_last;
  logic             load_code;

  assign gap_last     = CNT_W'(pick_gap(code_q, GAP_SEL0, GAP_SEL1,
                                        GAP_SEL2, GAP_SEL3) - 1);
  assign gap_done_o   = tick_i && !clear_i && (phase_q == PH_QUIET)
                        && (cnt_q == gap_last);
  assign pulse_done_o = tick_i && (phase_q == PH_PULSE)
                        && (cnt_q == CNT_W'(PULSE_TICKS - 1));
  assign load_code    = load_pend_q || pulse_done_o || clear_i;
  assign active_o     = (phase_q == PH_PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q      <= 2'd0;
      load_pend_q <= 1'b1;
    end else begin
      load_pend_q <= 1'b0;
      if (load_code) begin
        code_q <= gap_sel_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_QUIET;
      cnt_q   <= '0;
    end else if (clear_i) begin
      phase_q <= PH_QUIET;
      cnt_q   <= '0;
    end else if (gap_done_o) begin
      phase_q <= PH_PULSE;
      cnt_q   <= '0;
    end else if (pulse_done_o) begin
      phase_q <= PH_QUIET;
      cnt_q   <= '0;
    end else if (tick_i) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/irq_pacer_drive.sv
module irq_pacer_drive (
  input  logic active_i,
  input  logic advance_i,
  output logic irq_o,
  output logic mirror_o,
  output logic diag_o,
  output logic busy_o
);
  always_comb begin
    irq_o    = active_i;
    busy_o   = active_i;
    mirror_o = !active_i;
    diag_o   = active_i ? advance_i : 1'b1;
  end
endmodule

// File: rtl/irq_pacer.sv
module irq_pacer
  import irq_pacer_pkg::*;
#(
  parameter int unsigned DIV_RATIO   = 4,
  parameter int unsigned PULSE_TICKS = 32,
  parameter int unsigned GAP_SEL0    = 768,
  parameter int unsigned GAP_SEL1    = 896,
  parameter int unsigned GAP_SEL2    = 1792,
  parameter int unsigned GAP_SEL3    = 1920
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] jmp_sel,
  input  logic       clear_i,
  input  logic       advance_i,
  output logic       irq_o,
  output logic       mirror_o,
  output logic       diag_o,
  output logic       busy_o
);
  localparam int unsigned MAX_TICKS = max_of(max_of(GAP_SEL0, GAP_SEL1),
                                             max_of(max_of(GAP_SEL2, GAP_SEL3),
                                                    PULSE_TICKS));
  localparam int unsigned CNT_W     = bits_for(MAX_TICKS + 1);

  logic tick_w;
  logic active_w;
  logic gap_done_w;
  logic pulse_done_w;

  irq_pacer_tick #(.DIV_RATIO(DIV_RATIO)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick_w)
  );

  irq_pacer_seq #(
    .PULSE_TICKS (PULSE_TICKS),
    .GAP_SEL0    (GAP_SEL0),
    .GAP_SEL1    (GAP_SEL1),
    .GAP_SEL2    (GAP_SEL2),
    .GAP_SEL3    (GAP_SEL3),
    .CNT_W       (CNT_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_w),
    .clear_i      (clear_i),
    .gap_sel_i    (jmp_sel),
    .active_o     (active_w),
    .gap_done_o   (gap_done_w),
    .pulse_done_o (pulse_done_w)
  );

  irq_pacer_drive u_drive (
    .active_i  (active_w),
    .advance_i (advance_i),
    .irq_o     (irq_o),
    .mirror_o  (mirror_o),
    .diag_o    (diag_o),
    .busy_o    (busy_o)
  );
endmodule

// File: rtl/irq_pacer_chk.sv
module irq_pacer_chk #(
  parameter int unsigned PULSE_CLKS   = 128,
  parameter int unsigned MAX_GAP_CLKS = 7680
) (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic gap_done,
  input logic pulse_done,
  input logic clear_i,
  input logic advance_i,
  input logic irq_o,
  input logic mirror_o,
  input logic diag_o,
  input logic busy_o
);
  int unsigned hi_run;
  int unsigned lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= 0;
      lo_run <= 0;
    end else begin
      hi_run <= irq_o ? hi_run + 1 : 0;
      lo_run <= (irq_o || clear_i) ? 0 : lo_run + 1;
    end
  end

  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  assert_tick_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ##4 tick);
  assert_change_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o != $past(irq_o)) && !$past(clear_i) |-> $past(tick));
  assert_gap_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lo_run <= MAX_GAP_CLKS);
  assert_gap_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gap_done |=> irq_o);
  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) && !$past(clear_i) |-> hi_run == PULSE_CLKS);
  assert_pulse_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run <= PULSE_CLKS);
  assert_pulse_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_done |=> !irq_o);
  assert_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mirror_o != irq_o);
  assert_diag_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> diag_o);
  assert_diag_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> diag_o == advance_i);
  assert_clear_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !irq_o && !busy_o);
  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o == irq_o);
endmodule

bind irq_pacer irq_pacer_chk #(
  .PULSE_CLKS   (PULSE_TICKS * DIV_RATIO),
  .MAX_GAP_CLKS (MAX_TICKS * DIV_RATIO)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick_w),
  .gap_done   (gap_done_w),
  .pulse_done (pulse_done_w),
  .clear_i    (clear_i),
  .advance_i  (advance_i),
  .irq_o      (irq_o),
  .mirror_o   (mirror_o),
  .diag_o     (diag_o),
  .busy_o     (busy_o)
);

// File: tb/irq_pacer_bench.sv
`timescale 1ns/1ps
module irq_pacer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] jmp_sel = 2'd0;
  logic       clear_i = 1'b0;
  logic       advance_i = 1'b0;
  logic       irq_o, mirror_o, diag_o, busy_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  irq_pacer u_irq_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .jmp_sel   (jmp_sel),
    .clear_i   (clear_i),
    .advance_i (advance_i),
    .irq_o     (irq_o),
    .mirror_o  (mirror_o),
    .diag_o    (diag_o),
    .busy_o    (busy_o)
  );

  function automatic int gap_ticks(input logic [1:0] code);
    return 'h300 + (code[0] ? 'h80 : 0) + (code[1] ? 'h400 : 0);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Count quiet samples; optionally change jumper at sample chg_at (R4).
  task automatic count_low(output int n, input int chg_at, input logic [1:0] chg_val);
    int bad = 0;
    n = 0;
    while (irq_o == 1'b0 && !done) begin
      if (!(mirror_o == 1'b1 && diag_o == 1'b1 && busy_o == 1'b0)) bad++;
      if (n == chg_at) jmp_sel = chg_val;
      n++;
      @(negedge clk);
    end
    chk(bad == 0, "R5/R6/R10 quiet levels", bad, 0);
  endtask

  task automatic count_high(output int n);
    int bad = 0;
    n = 0;
    while (irq_o == 1'b1 && !done) begin
      advance_i = 1'($urandom);
      #1;
      if (!(mirror_o == 1'b0 && diag_o == advance_i && busy_o == 1'b1)) bad++;
      n++;
      @(negedge clk);
    end
    chk(bad == 0, "R5/R6/R10 active levels", bad, 0);
  endtask

  initial begin : watchdog
    while (cycles < 150000 && !done) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    int n;
    int g;
    logic [1:0] cur;
    logic [1:0] nxt;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    // R8: reset levels
    chk(irq_o == 1'b0 && busy_o == 1'b0, "R8 reset irq/busy", irq_o, 0);
    chk(mirror_o == 1'b1 && diag_o == 1'b1, "R8 reset mirror/diag", mirror_o, 1);
    rst_n = 1'b1;
    count_low(n, -1, 2'd0);
    g = 4 * gap_ticks(2'd0);
    chk(n >= g - 4 && n <= g + 1, "R8 first gap", n, g);

    // R1 R2 R3 R4: each jumper setting, jumper changed mid-gap
    cur = 2'd0;
    for (int k = 0; k < 8; k++) begin
      nxt = (k < 3) ? 2'(k + 1) : 2'($urandom_range(0, 3));
      count_high(n);
      chk(n == 128, "R3 R1 pulse width", n, 128);
      count_low(n, 40 + int'($urandom_range(0, 500)), nxt);
      chk(n == 4 * gap_ticks(cur), "R2 R4 gap length", n, 4 * gap_ticks(cur));
      cur = nxt;
    end

    // R7: clear in the middle of a pulse
    repeat (10) @(negedge clk);
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    chk(irq_o == 1'b0 && busy_o == 1'b0 && mirror_o == 1'b1, "R7 clear drops", irq_o, 0);
    count_low(n, -1, 2'd0);
    g = 4 * gap_ticks(cur);
    chk(n >= g - 3 && n <= g, "R7 gap restart after mid-pulse clear", n, g);

    // R7: held clear keeps request quiet; jumper sampled on clear (R4)
    cur = 2'd3;
    jmp_sel = cur;
    clear_i = 1'b1;
    @(negedge clk);
    begin
      int hi = 0;
      for (int i = 0; i < 9000; i++) begin
        if (irq_o) hi++;
        @(negedge clk);
      end
      chk(hi == 0, "R7 held clear keeps irq low", hi, 0);
    end
    clear_i = 1'b0;
    count_low(n, -1, 2'd0);
    g = 4 * gap_ticks(cur);
    chk(n >= g - 3 && n <= g, "R7 gap after held clear", n, g);

    // R9: clear on the same tick as pulse end
    cur = 2'd1;
    jmp_sel = cur;
    repeat (127) @(negedge clk);
    chk(irq_o == 1'b1, "R9 still active at last sample", irq_o, 1);
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    count_low(n, -1, 2'd0);
    chk(n == 4 * gap_ticks(cur), "R9 coincident clear gap", n, 4 * gap_ticks(cur));
    count_high(n);
    chk(n == 128, "R3 pulse after coincident clear", n, 128);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule